// File: doc/BRIEF.md
# Serial Receiver with Command-Controlled Holding Queue

This block receives 8-bit asynchronous characters from a serial line that is sampled at sixteen times the bit rate. The line passes through a short synchronizer into a serial shift register. Each completed character is appended to a three-entry first-in first-out holding queue, and a bus master drains the queue with a read strobe. The oldest held character is always on the data output. Ready and full flags report how many entries are occupied. An overrun flag records that a character completed while no entry was free.

Reception is switched on and off by a 2-bit command that is written with a strobe. One code switches the receiver on and restarts the hunt for a start bit. Another code switches it off at once and drops any character that is partly shifted in. The remaining two codes do nothing. While the local loop-back or multidrop mode input is high, the receiver keeps running whatever the command state is. While multidrop mode is high, the enable command is refused. The baud oversample tick comes from outside the block. Parity and framing checks are outside this block.

Top module: `serial_rx_queue`

## Requirements
- R1: After system reset `rd_data` is 0x00, `rx_ready`, `rx_full` and `rx_overrun` are 0, and the receiver is disabled, so a frame on `rx_line` is not received.
- R2: A frame is one low start bit, 8 data bits sent least significant bit first, and one high stop bit, each bit lasting 16 `baud_tick` pulses. Once the stop bit has been sampled, the received byte is appended to the holding queue.
- R3: `rd_data` shows the oldest held byte. A `rd_strobe` pulse removes that byte and exposes the next one in arrival order. When the queue is empty, `rd_data` is 0x00.
- R4: `rx_ready` is 1 while at least one of the three entries is occupied. `rx_full` is 1 while all three entries are occupied.
- R5: When a byte completes while all three entries are occupied, `rx_overrun` is set and the queue is left unchanged. The byte stays in the shift register and is appended as soon as a read frees an entry, provided the next start bit has not yet been accepted.
- R6: `rx_overrun` stays 1 until an `ovr_clear` pulse or a system reset.
- R7: Command code 2'b00 and the reserved code 2'b11 leave the enabled or disabled state unchanged.
- R8: Command code 2'b01 enables the receiver and restarts the start-bit search, but only when `multi_mode` is 0. Issued to a receiver that is already enabled, it does not disturb a character in progress.
- R9: Command code 2'b10 disables the receiver in the cycle it is accepted and discards a partly received character. The queue contents and `rx_overrun` are unchanged. A disabled receiver ignores `rx_line`.
- R10: While `loop_mode` or `multi_mode` is 1, the receiver operates even if it has been disabled by command, and a disable command does not interrupt a character.
- R11: A low level that is seen on a tick starts a character only if the line is still low at the mid-bit sample, 8 ticks later. Otherwise the receiver returns to searching and no byte is produced.
- R12: A `rd_strobe` while the queue is empty is ignored, and it does not disturb later reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cmd_valid | input | 1 | Strobe that accepts `cmd_code` |
| cmd_code | input | 2 | 00 none, 01 enable, 10 disable, 11 reserved |
| loop_mode | input | 1 | Local loop-back mode; keeps the receiver running |
| multi_mode | input | 1 | Multidrop mode; keeps the receiver running and refuses enable |
| ovr_clear | input | 1 | Pulse that clears the overrun flag |
| rd_strobe | input | 1 | Removes the oldest held byte |
| rd_data | output | 8 | Oldest held byte, 0x00 when the queue is empty |
| rx_ready | output | 1 | At least one byte is held |
| rx_full | output | 1 | All three entries are occupied |
| rx_overrun | output | 1 | Sticky flag: a byte completed while the queue was full |

## Verification
The bench targets three corner cases: the fourth character that arrives while the queue is full, a disable that lands in the middle of a character, and a short low glitch on the line. If the overrun case were handled wrongly, the design would overwrite the oldest entry or lose the held byte after the next read. If the disable case were handled wrongly, a partial or shifted byte would appear in the queue. If glitches were accepted as start bits, a spurious byte would appear, or the following real frame would be misaligned. The bench also checks that multidrop refuses the enable command, that both override modes keep a disabled receiver running, and that the reserved code and a read from an empty queue have no effect.

// File: rtl/srxq_pkg.sv
package srxq_pkg;

   typedef enum logic [1:0] {
      RXCMD_HOLD = 2'b00,
      RXCMD_ON   = 2'b01,
      RXCMD_OFF  = 2'b10,
      RXCMD_RSVD = 2'b11
   } rx_cmd_e;

   typedef enum logic [1:0] {
      SH_SEARCH,
      SH_START,
      SH_DATA,
      SH_STOP
   } shift_state_e;

endpackage

// File: rtl/srxq_ctrl.sv
module srxq_ctrl
   import srxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_code,
   input  logic       loop_mode,
   input  logic       multi_mode,
   input  logic       ovr_set,
   input  logic       ovr_clear,
   output logic       run,
   output logic       restart,
   output logic       abort,
   output logic       ovr
);

   rx_cmd_e cmd;
   logic    rx_en;
   logic    do_on;
   logic    do_off;

   assign cmd    = rx_cmd_e'(cmd_code);
   // HOLD and RSVD fall through: neither decodes to an action
   assign do_on  = cmd_valid && (cmd == RXCMD_ON) && !multi_mode && !rx_en;
   assign do_off = cmd_valid && (cmd == RXCMD_OFF) && rx_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en <= 1'b0;
      end else if (do_on) begin
         rx_en <= 1'b1;
      end else if (do_off) begin
         rx_en <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr <= 1'b0;
      end else if (ovr_set) begin
         ovr <= 1'b1;
      end else if (ovr_clear) begin
         ovr <= 1'b0;
      end
   end

   assign run     = rx_en || loop_mode || multi_mode;
   assign restart = do_on;
   assign abort   = do_off && !loop_mode && !multi_mode;

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !ovr_clear |=> ovr); // R6

   AST_MD_REFUSES_ON: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == 2'b01 && multi_mode && !rx_en |=> !rx_en); // R8

   AST_NOP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_code == 2'b00 || cmd_code == 2'b11) |=> $stable(rx_en)); // R7

endmodule

// File: rtl/srxq_shifter.sv
module srxq_shifter
   import srxq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_line,
   input  logic              run,
   input  logic              restart,
   input  logic              abort,
   input  logic              space,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              ovr_set
);

   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
   localparam logic [BIT_W-1:0] TOP_B  = BIT_W'(DATA_W - 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic rx_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_line;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '1;
         end else if (SYNC_STAGES == 1) begin
            chain[0] <= rx_line;
         end else begin
            chain <= {chain[SYNC_STAGES-2:0], rx_line};
         end
      end
      assign rx_s = chain[SYNC_STAGES-1];
   end

   shift_state_e      state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  nbits;
   logic [DATA_W-1:0] shreg;
   logic              pending;
   logic              active;
   logic              complete;

   assign active   = run && !abort && !restart;
   assign complete = active && tick && (state == SH_STOP) && (cnt == LAST_C);
   assign push     = space && (complete || pending);
   assign ovr_set  = complete && !space;
   assign push_data = shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SH_SEARCH;
         cnt     <= '0;
         nbits   <= '0;
         shreg   <= '0;
         pending <= 1'b0;
      end else begin
         if (push) begin
            pending <= 1'b0;
         end
         if (!active) begin
            state <= SH_SEARCH;
            cnt   <= '0;
         end else if (tick) begin
            unique case (state)
               SH_SEARCH: begin
                  if (!rx_s) begin
                     state <= SH_START;
                     cnt   <= '0;
                  end
               end
               SH_START: begin
                  if (cnt == MID_C) begin
                     cnt <= '0;
                     if (!rx_s) begin
                        state   <= SH_DATA;
                        nbits   <= '0;
                        pending <= 1'b0;
                     end else begin
                        state <= SH_SEARCH;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SH_DATA: begin
                  if (cnt == LAST_C) begin
                     cnt   <= '0;
                     nbits <= nbits + 1'b1;
                     if (DATA_W == 1) begin
                        shreg <= rx_s;
                     end else begin
                        shreg <= {rx_s, shreg[DATA_W-1:1]};
                     end
                     if (nbits == TOP_B) begin
                        state <= SH_STOP;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SH_STOP: begin
                  if (cnt == LAST_C) begin
                     state <= SH_SEARCH;
                     cnt   <= '0;
                     if (!space) begin
                        pending <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= SH_SEARCH;
            endcase
         end
      end
   end

   AST_ABORT_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> state == SH_SEARCH && cnt == '0); // R9

   AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      active && tick && state == SH_START && cnt == MID_C && rx_s
      |=> state == SH_SEARCH); // R11

   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      pending && state != SH_DATA |=> $stable(shreg)); // R5

endmodule

// File: rtl/srxq_holdfifo.sv
module srxq_holdfifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              rd,
   output logic [DATA_W-1:0] dout,
   output logic              space,
   output logic              ready,
   output logic              full
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be positive");
   end

   logic [DATA_W-1:0] slot     [DEPTH];
   logic [DATA_W-1:0] slot_nxt [DEPTH];
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  wr_idx;
   logic              rd_acc;

   assign rd_acc = rd && (count != '0);
   assign space  = (count != DEPTH_C) || rd_acc;
   assign wr_idx = count - CNT_W'(rd_acc);
   assign ready  = (count != '0);
   assign full   = (count == DEPTH_C);
   assign dout   = slot[0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] shifted;
      if (i == DEPTH - 1) begin : g_top
         assign shifted = '0;
      end else begin : g_mid
         assign shifted = slot[i+1];
      end
      always_comb begin
         slot_nxt[i] = rd_acc ? shifted : slot[i];
         if (push && wr_idx == CNT_W'(i)) begin
            slot_nxt[i] = din;
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot[i] <= '0;
         end else begin
            slot[i] <= slot_nxt[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count + CNT_W'(push) - CNT_W'(rd_acc);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> space); // R5

   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      count == '0 |-> dout == '0); // R3

   AST_IGNORE_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd && count == '0 && !push |=> count == '0); // R12

   if (DEPTH > 1) begin : g_order_chk
      AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         rd_acc && count > CNT_W'(1) |=> dout == $past(slot[1])); // R3
   end

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 3,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx_line,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_code,
   input  logic              loop_mode,
   input  logic              multi_mode,
   input  logic              ovr_clear,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_ready,
   output logic              rx_full,
   output logic              rx_overrun
);

   logic              run;
   logic              restart;
   logic              abort;
   logic              space;
   logic              push;
   logic [DATA_W-1:0] push_data;
   logic              ovr_set;

   srxq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .loop_mode  (loop_mode),
      .multi_mode (multi_mode),
      .ovr_set    (ovr_set),
      .ovr_clear  (ovr_clear),
      .run        (run),
      .restart    (restart),
      .abort      (abort),
      .ovr        (rx_overrun)
   );

   srxq_shifter #(
      .DATA_W      (DATA_W),
      .OSR         (OSR),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .rx_line   (rx_line),
      .run       (run),
      .restart   (restart),
      .abort     (abort),
      .space     (space),
      .push      (push),
      .push_data (push_data),
      .ovr_set   (ovr_set)
   );

   srxq_holdfifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (push_data),
      .rd    (rd_strobe),
      .dout  (rd_data),
      .space (space),
      .ready (rx_ready),
      .full  (rx_full)
   );

   AST_FULL_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_ready); // R4

   AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> rx_full); // R5

endmodule

// File: tb/test_serial_rx_queue.sv
module test_serial_rx_queue;

   localparam int BIT_CLK = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_code = 2'b00;
   logic       loop_mode = 1'b0;
   logic       multi_mode = 1'b0;
   logic       ovr_clear = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       rx_ready;
   logic       rx_full;
   logic       rx_overrun;

   int checks = 0;
   int fails  = 0;

   // each entry: {byte sent, byte expected}
   localparam logic [15:0] VEC [6] = '{16'hA5A5, 16'h0000, 16'hFFFF,
                                       16'h3C3C, 16'h8181, 16'h5A5A};

   serial_rx_queue i_serial_rx_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .rx_line    (rx_line),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .loop_mode  (loop_mode),
      .multi_mode (multi_mode),
      .ovr_clear  (ovr_clear),
      .rd_strobe  (rd_strobe),
      .rd_data    (rd_data),
      .rx_ready   (rx_ready),
      .rx_full    (rx_full),
      .rx_overrun (rx_overrun)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         baud_tick = ~baud_tick;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] b);
      rx_line = 1'b0;
      repeat (BIT_CLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         repeat (BIT_CLK) @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (BIT_CLK) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic command(input logic [1:0] c);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = c;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 2'b00;
   endtask

   task automatic pop(input logic [7:0] exp, input string tag);
      @(negedge clk);
      check(rd_data == exp, tag, rd_data, exp);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      check(rx_ready == 1'b0, "R1 ready", rx_ready, 0);
      check(rx_full == 1'b0, "R1 full", rx_full, 0);
      check(rx_overrun == 1'b0, "R1 overrun", rx_overrun, 0);
      send_frame(8'h11);
      check(rx_ready == 1'b0, "R1 disabled after reset", rx_ready, 0);

      command(2'b01);
      // R2 R3 table walk
      for (int v = 0; v < 6; v++) begin
         send_frame(VEC[v][15:8]);
         check(rx_ready == 1'b1, "R2 ready after frame", rx_ready, 1);
         pop(VEC[v][7:0], "R2 received byte");
      end
      check(rx_ready == 1'b0, "R4 ready after drain", rx_ready, 0);

      // R12 read while empty
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check(rd_data == 8'h00 && rx_ready == 1'b0, "R12 empty read", rd_data, 0);
      send_frame(8'h6E);
      pop(8'h6E, "R12 reception after empty read");

      // R3 R4 fill three
      send_frame(8'h12);
      check(rx_full == 1'b0, "R4 full with one", rx_full, 0);
      send_frame(8'h34);
      send_frame(8'h56);
      check(rx_full == 1'b1, "R4 full with three", rx_full, 1);
      check(rd_data == 8'h12, "R3 oldest on output", rd_data, 8'h12);
      check(rx_overrun == 1'b0, "R5 no overrun yet", rx_overrun, 0);
      // R5 overrun
      send_frame(8'h78);
      check(rx_overrun == 1'b1, "R5 overrun set", rx_overrun, 1);
      check(rx_full == 1'b1, "R5 still full", rx_full, 1);
      pop(8'h12, "R5 oldest kept");
      pop(8'h34, "R3 order second");
      pop(8'h56, "R3 order third");
      pop(8'h78, "R5 held byte appended");
      check(rx_ready == 1'b0, "R4 empty again", rx_ready, 0);
      check(rd_data == 8'h00, "R3 empty output zero", rd_data, 0);
      check(rx_overrun == 1'b1, "R6 overrun sticky", rx_overrun, 1);
      @(negedge clk);
      ovr_clear = 1'b1;
      @(negedge clk);
      ovr_clear = 1'b0;
      check(rx_overrun == 1'b0, "R6 overrun cleared", rx_overrun, 0);

      // R7 no-action codes while enabled
      command(2'b00);
      command(2'b11);
      send_frame(8'hC9);
      pop(8'hC9, "R7 still enabled");

      // R8 enable while enabled does not disturb
      fork
         send_frame(8'h96);
         begin
            repeat (120) @(negedge clk);
            command(2'b01);
         end
      join
      pop(8'h96, "R8 repeat enable harmless");

      // R11 glitch rejected
      @(negedge clk);
      rx_line = 1'b0;
      repeat (6) @(negedge clk);
      rx_line = 1'b1;
      repeat (60) @(negedge clk);
      check(rx_ready == 1'b0, "R11 glitch rejected", rx_ready, 0);
      send_frame(8'hE1);
      pop(8'hE1, "R11 frame after glitch");

      // R9 disable mid-character
      fork
         send_frame(8'hC3);
         begin
            repeat (100) @(negedge clk);
            command(2'b10);
         end
      join
      check(rx_ready == 1'b0, "R9 partial dropped", rx_ready, 0);
      check(rx_overrun == 1'b0, "R9 status unchanged", rx_overrun, 0);
      send_frame(8'h5C);
      check(rx_ready == 1'b0, "R9 disabled ignores line", rx_ready, 0);
      command(2'b11);
      send_frame(8'h5D);
      check(rx_ready == 1'b0, "R7 reserved code no enable", rx_ready, 0);

      // R10 multidrop override; R8 enable refused
      multi_mode = 1'b1;
      @(negedge clk);
      send_frame(8'h4B);
      pop(8'h4B, "R10 multidrop receives");
      command(2'b01);
      multi_mode = 1'b0;
      @(negedge clk);
      send_frame(8'h2D);
      check(rx_ready == 1'b0, "R8 enable refused in multidrop", rx_ready, 0);

      // R10 loop-back override, disable during frame
      loop_mode = 1'b1;
      @(negedge clk);
      fork
         send_frame(8'h71);
         begin
            repeat (100) @(negedge clk);
            command(2'b10);
         end
      join
      pop(8'h71, "R10 loop-back receives");
      loop_mode = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule